// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early Warning

This block watches over software running on the bus clock. A counter in a separate slow watchdog clock domain counts up from zero. If software does not write the service key to the kick register before the counter reaches the programmed period, the block raises a reset request. The period and the early-warning point are each a power-of-two code. A service write that carries the wrong key raises the reset request at once. In window mode, a correct service write that comes too soon after the last restart also raises it.

Software configures the block through a small register port on the bus clock. Writes to control, timing, warning and kick cross into the watchdog clock through a toggle handshake. A busy bit stays high until the watchdog domain has taken the write. The early-warning event comes back into the bus domain and sets a flag. That flag drives an interrupt line only when software has enabled it, and software clears it by writing one.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, wd_rst_req and wd_irq are 0 and every register reads back as 0.
- R2: Once enabled, the reset request rises 8 << P watchdog cycles after the count restarts, where P is the 4-bit period code and any code above 11 acts as 11 (16384 cycles).
- R3: Writing 0xA5 to the kick register while the watchdog runs restarts the count from zero.
- R4: Writing any other value to the kick register while the watchdog runs raises the reset request within a few watchdog cycles.
- R5: The warning flag (address 4, bit 0) sets 8 << W cycles after a restart, where W is the warning code (W above 11 acts as 11). It sets only if that point falls before the timeout. wd_irq is high only while both the flag and the interrupt enable (address 3, bit 0) are set. Writing 1 to flag bit 0 clears it.
- R6: A write to control, timing, warning or kick sets busy (address 6, bit 0) until the watchdog domain has applied it. While busy is high, further writes to those four registers are ignored, and that includes kicks.
- R7: While the enable bit (address 0, bit 0) is clear, the watchdog neither counts nor raises a reset request, and kick writes have no effect.
- R8: With the window bit (address 0, bit 1) set, a correct kick that arrives fewer than 8 << C cycles after a restart raises the reset request. C is the closed-window code in timing bits 7:4. A correct kick that arrives later restarts the count.
- R9: Once raised, wd_rst_req stays high until rst is applied.
- R10: Register map: 0 control {window, enable} in bits 1:0, 1 timing {closed code[7:4], period code[3:0]}, 2 warning code[3:0], 3 interrupt enable, 4 warning flag, 5 kick (reads 0), 6 status busy. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| wd_clk | input | 1 | Slow watchdog clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for bus_addr |
| wd_irq | output | 1 | Early-warning interrupt, gated by its enable |
| wd_rst_req | output | 1 | Sticky system reset request, watchdog clock domain |

## Verification
The hardest state to reach from the ports is a kick that lands while busy is still high. The bench brings it about by issuing a wrong-key kick on the bus cycle right after the enable write. Because the kick is dropped, no early reset may follow, and the full period must elapse. The window case is also delicate, because the closed period is counted from the moment the watchdog domain applies a write, not from the bus write. The bench therefore times each kick relative to the fall of busy, which it observes through the status register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CODE_W  = 4;
  localparam logic [7:0]  SVC_KEY = 8'hA5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_TIME = 3'd1,
    A_WARN = 3'd2,
    A_IEN  = 3'd3,
    A_FLAG = 3'd4,
    A_KICK = 3'd5,
    A_STAT = 3'd6
  } addr_e;

  // command carried across the clock boundary
  typedef struct packed {
    logic              en;
    logic              wen;
    logic [CODE_W-1:0] per;
    logic [CODE_W-1:0] win;
    logic [CODE_W-1:0] ew;
    logic              kick;
    logic [7:0]        key;
  } cmd_t;

  function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] c, input int unsigned lim);
    return (int'(c) > int'(lim)) ? CODE_W'(lim) : c;
  endfunction
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[0] <= 1'b0;
          else     sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr[i] <= 1'b0;
          else     sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int MAX_CODE = 11,
  parameter int CNT_W    = MAX_CODE + 4
) (
  input  logic clk,
  input  logic rst,
  input  logic apply,
  input  cmd_t cmd,
  output logic rst_req,
  output logic ew_tgl
);
  logic              en_q, wen_q;
  logic [CODE_W-1:0] per_q, win_q, ew_q;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [CNT_W-1:0] span(input logic [CODE_W-1:0] c);
    return CNT_W'(8) << sat_code(c, MAX_CODE);
  endfunction

  logic running, tmo_hit, ew_hit, kick_live, kick_bad, kick_good, cfg_apply;

  always_comb begin
    running   = en_q && !rst_req;
    tmo_hit   = running && (cnt == span(per_q) - CNT_W'(1));
    ew_hit    = running && (span(ew_q) < span(per_q)) && (cnt == span(ew_q) - CNT_W'(1));
    kick_live = apply && cmd.kick && running;
    kick_bad  = kick_live && ((cmd.key != SVC_KEY) || (wen_q && (cnt < span(win_q))));
    kick_good = kick_live && !kick_bad;
    cfg_apply = apply && !cmd.kick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      wen_q   <= 1'b0;
      per_q   <= '0;
      win_q   <= '0;
      ew_q    <= '0;
      cnt     <= '0;
      rst_req <= 1'b0;
      ew_tgl  <= 1'b0;
    end else begin
      if (cfg_apply) begin
        en_q  <= cmd.en;
        wen_q <= cmd.wen;
        per_q <= cmd.per;
        win_q <= cmd.win;
        ew_q  <= cmd.ew;
      end
      if (tmo_hit || kick_bad) rst_req <= 1'b1;
      if (ew_hit) ew_tgl <= ~ew_tgl;
      if (cfg_apply || kick_good)  cnt <= '0;
      else if (running && !tmo_hit) cnt <= cnt + CNT_W'(1);
    end
  end

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req); // R9
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(en_q)); // R7
  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (cnt < span(per_q))); // R2
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int MAX_CODE    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              wd_clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wd_irq,
  output logic              wd_rst_req
);
  localparam int CNT_W = MAX_CODE + 4;

  // ---------------- bus domain ----------------
  logic              en_r, wen_r, ie_r, flag_r, req_t, irq_r;
  logic [CODE_W-1:0] per_r, win_r, ew_r;
  cmd_t              cmd_r, cmd_nx;
  logic [7:0]        rdata_r;
  logic              ack_s, ew_s, ew_d, ew_pulse, busy, sync_wr;

  always_comb begin
    busy     = req_t ^ ack_s;
    ew_pulse = ew_s ^ ew_d;
    sync_wr  = bus_we && !busy &&
               ((bus_addr == A_CTRL) || (bus_addr == A_TIME) ||
                (bus_addr == A_WARN) || (bus_addr == A_KICK));
    cmd_nx   = '{en: en_r, wen: wen_r, per: per_r, win: win_r, ew: ew_r, kick: 1'b0, key: 8'h00};
    case (bus_addr)
      A_CTRL: begin cmd_nx.en = bus_wdata[0]; cmd_nx.wen = bus_wdata[1]; end
      A_TIME: begin cmd_nx.per = bus_wdata[3:0]; cmd_nx.win = bus_wdata[7:4]; end
      A_WARN: cmd_nx.ew = bus_wdata[3:0];
      A_KICK: begin cmd_nx.kick = 1'b1; cmd_nx.key = bus_wdata; end
      default: ;
    endcase
  end

  always_ff @(posedge bus_clk) begin
    if (rst) begin
      en_r <= 1'b0; wen_r <= 1'b0; ie_r <= 1'b0; flag_r <= 1'b0;
      req_t <= 1'b0; irq_r <= 1'b0; ew_d <= 1'b0;
      per_r <= '0; win_r <= '0; ew_r <= '0;
      cmd_r <= '0; rdata_r <= '0;
    end else begin
      ew_d <= ew_s;
      if (sync_wr) begin
        req_t <= ~req_t;
        cmd_r <= cmd_nx;
        en_r  <= cmd_nx.en;
        wen_r <= cmd_nx.wen;
        per_r <= cmd_nx.per;
        win_r <= cmd_nx.win;
        ew_r  <= cmd_nx.ew;
      end
      if (bus_we && bus_addr == A_IEN) ie_r <= bus_wdata[0];
      if (ew_pulse) flag_r <= 1'b1;
      else if (bus_we && bus_addr == A_FLAG && bus_wdata[0]) flag_r <= 1'b0;
      irq_r <= flag_r & ie_r;
      case (bus_addr)
        A_CTRL:  rdata_r <= {6'd0, wen_r, en_r};
        A_TIME:  rdata_r <= {win_r, per_r};
        A_WARN:  rdata_r <= {4'd0, ew_r};
        A_IEN:   rdata_r <= {7'd0, ie_r};
        A_FLAG:  rdata_r <= {7'd0, flag_r};
        A_STAT:  rdata_r <= {7'd0, busy};
        default: rdata_r <= 8'h00;
      endcase
    end
  end

  assign bus_rdata = rdata_r;
  assign wd_irq    = irq_r;

  // ---------------- watchdog domain ----------------
  logic req_q, ack_t, apply, ew_tgl;

  wdog_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk(wd_clk), .rst(rst), .d(req_t), .q(req_q));

  always_ff @(posedge wd_clk) begin
    if (rst) ack_t <= 1'b0;
    else     ack_t <= req_q;
  end
  assign apply = req_q ^ ack_t;

  wdog_core #(.MAX_CODE(MAX_CODE), .CNT_W(CNT_W)) i_core (
    .clk(wd_clk), .rst(rst), .apply(apply), .cmd(cmd_r),
    .rst_req(wd_rst_req), .ew_tgl(ew_tgl));

  // ---------------- return paths ----------------
  wdog_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk(bus_clk), .rst(rst), .d(ack_t), .q(ack_s));
  wdog_sync #(.STAGES(SYNC_STAGES)) i_ew_sync (
    .clk(bus_clk), .rst(rst), .d(ew_tgl), .q(ew_s));

  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge bus_clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_r)); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge bus_clk) disable iff (rst)
    wd_irq |-> $past(ie_r)); // R5
  AST_FLAG_FROM_WARNING: assert property (@(posedge bus_clk) disable iff (rst)
    $rose(flag_r) |-> $past(ew_pulse)); // R5
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int BUS_PERIOD = 10;
  localparam int WD_PERIOD  = 4 * BUS_PERIOD;
  localparam logic [2:0] RA_CTRL = 3'd0, RA_TIME = 3'd1, RA_WARN = 3'd2, RA_IEN = 3'd3,
                         RA_FLAG = 3'd4, RA_KICK = 3'd5, RA_STAT = 3'd6;

  typedef struct packed {
    logic [3:0] per;
    logic [3:0] ew;
    int         tmo;
    int         ewn;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  4'd0,  16,    8},
    '{4'd2,  4'd1,  32,    16},
    '{4'd3,  4'd0,  64,    8},
    '{4'd4,  4'd2,  128,   32},
    '{4'd15, 4'd10, 16384, 8192}
  };

  logic bus_clk = 1'b0, wd_clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic wd_irq, wd_rst_req;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always #(WD_PERIOD/2)  wd_clk  = ~wd_clk;

  keyed_watchdog i_keyed_watchdog (
    .bus_clk(bus_clk), .wd_clk(wd_clk), .rst(rst), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .wd_rst_req(wd_rst_req));

  always @(posedge bus_clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge bus_clk); #1 rst = 1'b1;
    repeat (6) @(posedge wd_clk);
    @(posedge bus_clk); #1 rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge bus_clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge bus_clk); bus_we = 1'b0; bus_addr = a;
    @(negedge bus_clk); v = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    v = 8'h01;
    for (int i = 0; i < 60 && v[0]; i++) rd(RA_STAT, v);
    check(v[0] == 1'b0, req, int'(v[0]), 0);
  endtask

  task automatic wait_wd(input int n);
    repeat (n) @(negedge wd_clk);
  endtask

  task automatic measure(input int lim, output int ew_n, output int rst_n);
    ew_n = -1; rst_n = -1;
    for (int n = 1; n <= lim; n++) begin
      @(negedge wd_clk);
      if (wd_irq && ew_n < 0) ew_n = n;
      if (wd_rst_req) begin rst_n = n; break; end
    end
  endtask

  initial begin
    logic [7:0] v;
    int e, r;

    // R1 reset state, R10 reads
    do_reset();
    check(wd_rst_req == 1'b0, "R1 rst_req after reset", int'(wd_rst_req), 0);
    check(wd_irq == 1'b0, "R1 irq after reset", int'(wd_irq), 0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check(v == 8'h00, "R1 register reset value", int'(v), 0);
    end

    // R10 readback
    wr(RA_TIME, 8'h2B); wait_idle("R6 busy clears");
    rd(RA_TIME, v); check(v == 8'h2B, "R10 timing readback", int'(v), 8'h2B);
    wr(RA_WARN, 8'h07); wait_idle("R6 busy clears");
    rd(RA_WARN, v); check(v == 8'h07, "R10 warning readback", int'(v), 7);
    wr(RA_CTRL, 8'h02); wait_idle("R6 busy clears");
    rd(RA_CTRL, v); check(v == 8'h02, "R10 control readback", int'(v), 2);
    wr(RA_IEN, 8'h01);
    rd(RA_IEN, v); check(v == 8'h01, "R10 enable readback", int'(v), 1);
    rd(RA_KICK, v); check(v == 8'h00, "R10 kick reads zero", int'(v), 0);

    // vector table: R2 period codes incl. saturation, R5 warning point
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr(RA_TIME, {4'd0, VECS[i].per}); wait_idle("R6 busy clears");
      wr(RA_WARN, {4'd0, VECS[i].ew});  wait_idle("R6 busy clears");
      wr(RA_IEN, 8'h01);
      wr(RA_CTRL, 8'h01); wait_idle("R6 busy clears");
      measure(VECS[i].tmo + 10, e, r);
      check(r >= VECS[i].tmo - 1 && r <= VECS[i].tmo + 1, "R2 timeout cycles", r, VECS[i].tmo);
      check(e >= VECS[i].ewn - 1 && e <= VECS[i].ewn + 2, "R5 warning cycles", e, VECS[i].ewn);
      wait_wd(20);
      check(wd_rst_req == 1'b1, "R9 request stays high", int'(wd_rst_req), 1);
    end
    do_reset();
    check(wd_rst_req == 1'b0, "R9 request cleared by reset", int'(wd_rst_req), 0);

    // R3 valid kick restarts count
    wr(RA_TIME, 8'h03); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h01); wait_idle("R6 busy clears");
    wait_wd(40);
    wr(RA_KICK, 8'hA5); wait_idle("R6 busy clears");
    check(wd_rst_req == 1'b0, "R3 no reset on valid kick", int'(wd_rst_req), 0);
    measure(80, e, r);
    check(r >= 63 && r <= 65, "R3 count restarted", r, 64);

    // R4 wrong key
    do_reset();
    wr(RA_TIME, 8'h04); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h01); wait_idle("R6 busy clears");
    wr(RA_KICK, 8'h5A);
    measure(8, e, r);
    check(r > 0, "R4 wrong key resets at once", r, 1);

    // R6 kick while busy is dropped
    do_reset();
    wr(RA_TIME, 8'h01); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h01);
    wr(RA_KICK, 8'h00);
    rd(RA_STAT, v);
    check(v[0] == 1'b1, "R6 busy seen after write", int'(v[0]), 1);
    wait_idle("R6 busy clears");
    measure(30, e, r);
    check(r >= 15 && r <= 17, "R6 busy-time kick ignored", r, 16);

    // R7 disabled watchdog
    do_reset();
    wr(RA_TIME, 8'h00); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h01); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h00); wait_idle("R6 busy clears");
    wait_wd(100);
    check(wd_rst_req == 1'b0, "R7 stopped watchdog", int'(wd_rst_req), 0);
    wr(RA_KICK, 8'h11); wait_idle("R6 busy clears");
    wait_wd(20);
    check(wd_rst_req == 1'b0, "R7 wrong key while disabled", int'(wd_rst_req), 0);

    // R5 interrupt gating and write-one-to-clear
    do_reset();
    wr(RA_TIME, 8'h03); wait_idle("R6 busy clears");
    wr(RA_WARN, 8'h01); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h01); wait_idle("R6 busy clears");
    wait_wd(25);
    check(wd_irq == 1'b0, "R5 irq masked", int'(wd_irq), 0);
    rd(RA_FLAG, v); check(v[0] == 1'b1, "R5 flag set", int'(v[0]), 1);
    wr(RA_IEN, 8'h01);
    @(negedge bus_clk);
    check(wd_irq == 1'b1, "R5 irq when enabled", int'(wd_irq), 1);
    wr(RA_FLAG, 8'h01);
    @(negedge bus_clk);
    check(wd_irq == 1'b0, "R5 irq after clear", int'(wd_irq), 0);
    rd(RA_FLAG, v); check(v[0] == 1'b0, "R5 flag cleared", int'(v[0]), 0);

    // R8 window mode: early kick
    do_reset();
    wr(RA_TIME, 8'h03); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h03); wait_idle("R6 busy clears");
    wr(RA_KICK, 8'hA5);
    measure(6, e, r);
    check(r > 0, "R8 early kick resets", r, 1);

    // R8 window mode: late kick
    do_reset();
    wr(RA_TIME, 8'h03); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h03); wait_idle("R6 busy clears");
    wait_wd(14);
    wr(RA_KICK, 8'hA5); wait_idle("R6 busy clears");
    check(wd_rst_req == 1'b0, "R8 late kick accepted", int'(wd_rst_req), 0);
    measure(80, e, r);
    check(r >= 63 && r <= 65, "R8 late kick restarts", r, 64);

    // R8 wider closed window (code 2 = 32 cycles)
    do_reset();
    wr(RA_TIME, 8'h24); wait_idle("R6 busy clears");
    wr(RA_CTRL, 8'h03); wait_idle("R6 busy clears");
    wait_wd(20);
    wr(RA_KICK, 8'hA5);
    measure(6, e, r);
    check(r > 0, "R8 kick inside wider window", r, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule